// File: doc/BRIEF.md
# PS/2 Port Host Register Front End

This block is the software-facing side of a keyboard or mouse serial port. A plain word-addressed bus reaches five registers: control, status, receive/transmit data, a clock divisor and an interrupt status word. The top of a 4 KB window holds a fixed, read-only identification area. An external line receiver hands over finished bytes on a valid/data pair. The block keeps the most recent byte until software takes it from the data register. A software write to the data register goes out as one byte with a one-cycle strobe toward an external line transmitter.

The block drives a single level interrupt. That line is high when a byte is waiting and receive interrupts are enabled, or whenever the transmit interrupt enable is set. The status word reports a receive-full flag and the parity of the byte last handed to software. It also always shows the transmitter as empty. Read data is registered: it appears on the cycle after the read strobe and holds until the next read.

Top module: `ps2_host_regs`

## Requirements
- R1: After reset, control, divisor, held byte and pending flag are zero and `irq` is low. Read data is registered: `bus_rdata` changes only on the cycle after a cycle with `bus_rd` high.
- R2: Control (offset 0x00) and divisor (offset 0x0C) store the low 8 bits of a write, read back those bits, and read zero above bit 7.
- R3: A status read (offset 0x04) returns bit 6 = 1 (transmitter empty) and bit 4 = pending flag. Bits 5, 3, 1, 0 and all bits above 6 read 0.
- R4: Status bit 2 equals the XOR of all eight bits of the held byte, the byte most recently returned by a data read.
- R5: A byte on `rx_byte` with `rx_valid` high sets the pending flag. A data read (offset 0x08) while pending returns that byte, makes it the held byte and clears the pending flag.
- R6: A data read with nothing pending returns the held byte again and changes no state.
- R7: When a new byte arrives in the same cycle as a consuming data read, the read returns the older byte and the pending flag stays set, so the next data read returns the new byte.
- R8: `irq` = (pending AND control bit 4) OR control bit 3. It follows a control write on the next cycle.
- R9: An interrupt status read (offset 0x10) returns the pending flag in bit 0, a 1 in bit 1, and 0 elsewhere.
- R10: A write to offset 0x08 raises `tx_stb` for exactly the next cycle, with `tx_byte` equal to bits 7:0 of the write data.
- R11: Reads at 0xFE0 + 4*i for i = 0..7 return the identification bytes 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order of i.
- R12: Reads at unmapped offsets return 0. Writes to unmapped offsets, to status, to interrupt status or to the identification area change no register and raise no `tx_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the access (bits 1:0 ignored) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| rx_valid | input | 1 | Receiver presents a finished byte |
| rx_byte | input | 8 | Received byte |
| tx_stb | output | 1 | One-cycle send request |
| tx_byte | output | 8 | Byte to send |
| irq | output | 1 | Level interrupt |

## Verification
All 256 byte values are each received and then read. Each read is checked for the returned byte and for the parity bit computed arithmetically, so an error in any single bit of the XOR reduction shows. All 256 control values are written, with the pending flag both clear and set. This separates the gated receive term of the interrupt from the ungated transmit term and from other control bits. The divisor is swept through every value. Directed sequences cover reads with nothing pending, the same-cycle arrival and consume, the identification bytes, unmapped offsets, and writes that must do nothing.

// File: rtl/ps2r_pkg.sv
package ps2r_pkg;

  // word indices of the register map (byte offset >> 2)
  localparam int unsigned W_CTRL = 0;
  localparam int unsigned W_STAT = 1;
  localparam int unsigned W_DATA = 2;
  localparam int unsigned W_DIV  = 3;
  localparam int unsigned W_ISR  = 4;

  // status bit positions
  localparam int unsigned ST_TXEMPTY = 6;
  localparam int unsigned ST_RXFULL  = 4;
  localparam int unsigned ST_PARITY  = 2;

  // control bit positions feeding the interrupt
  localparam int unsigned CT_RXIE = 4;
  localparam int unsigned CT_TXIE = 3;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0:    b = 8'h50;
      3'd1:    b = 8'h10;
      3'd2:    b = 8'h04;
      3'd3:    b = 8'h00;
      3'd4:    b = 8'h0D;
      3'd5:    b = 8'hF0;
      3'd6:    b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/ps2r_rx_hold.sv
module ps2r_rx_hold #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              consume,
  output logic              pending,
  output logic [BYTE_W-1:0] rx_buf,
  output logic [BYTE_W-1:0] last_byte
);

  logic              pend_q, pend_d;
  logic [BYTE_W-1:0] buf_q, buf_d;
  logic [BYTE_W-1:0] last_q, last_d;
  logic              take;

  always_comb begin
    take   = consume & pend_q;
    // an arriving byte wins over the clear caused by a read
    pend_d = rx_valid | (pend_q & ~consume);
    buf_d  = rx_valid ? rx_byte : buf_q;
    last_d = take ? buf_q : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      buf_q  <= '0;
      last_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (rx_valid) buf_q  <= buf_d;
      if (take)     last_q <= last_d;
    end
  end

  assign pending   = pend_q;
  assign rx_buf    = buf_q;
  assign last_byte = last_q;

  AST_PEND_ON_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> pending); // R5

  AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !rx_valid) |=> !pending); // R5

  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(consume && pending) |=> $stable(last_byte)); // R6

  AST_HELD_FROM_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && pending) |=> last_byte == $past(rx_buf)); // R7

endmodule

// File: rtl/ps2r_read_mux.sv
module ps2r_read_mux
  import ps2r_pkg::*;
#(
  parameter int unsigned WORD_W = 10,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [WORD_W-1:0] word,
  input  logic              pending,
  input  logic [BYTE_W-1:0] rx_buf,
  input  logic [BYTE_W-1:0] last_byte,
  input  logic [BYTE_W-1:0] ctrl,
  input  logic [BYTE_W-1:0] div,
  output logic [BUS_W-1:0]  rdata
);

  logic is_id;
  logic parity;

  always_comb begin
    is_id  = &word[WORD_W-1:3];
    parity = ^last_byte;
    rdata  = '0;
    if (is_id) begin
      rdata[7:0] = id_byte(word[2:0]);
    end else begin
      case (word)
        WORD_W'(W_CTRL): rdata[BYTE_W-1:0] = ctrl;
        WORD_W'(W_STAT): begin
          rdata[ST_TXEMPTY] = 1'b1;
          rdata[ST_RXFULL]  = pending;
          rdata[ST_PARITY]  = parity;
        end
        WORD_W'(W_DATA): rdata[BYTE_W-1:0] = pending ? rx_buf : last_byte;
        WORD_W'(W_DIV):  rdata[BYTE_W-1:0] = div;
        WORD_W'(W_ISR):  rdata[1:0] = {1'b1, pending};
        default:         rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/ps2r_tx_port.sv
module ps2r_tx_port #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              send,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              tx_stb,
  output logic [BYTE_W-1:0] tx_byte
);

  logic              stb_q, stb_d;
  logic [BYTE_W-1:0] byte_q, byte_d;

  always_comb begin
    stb_d  = send;
    byte_d = byte_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q  <= 1'b0;
      byte_q <= '0;
    end else begin
      stb_q <= stb_d;
      if (send) byte_q <= byte_d;
    end
  end

  assign tx_stb  = stb_q;
  assign tx_byte = byte_q;

  AST_TX_FROM_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stb |-> $past(send)); // R10

  AST_TX_BYTE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    send |=> (tx_byte == $past(byte_in))); // R10

endmodule

// File: rtl/ps2_host_regs.sv
module ps2_host_regs
  import ps2r_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              tx_stb,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              irq
);

  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              is_id;
  logic              wr_ctrl, wr_div, wr_data, rd_data;
  logic [BYTE_W-1:0] ctrl_q, ctrl_d;
  logic [BYTE_W-1:0] div_q, div_d;
  logic [BUS_W-1:0]  rdata_q, rdata_d;
  logic              pending;
  logic [BYTE_W-1:0] rx_buf, last_byte;
  logic              irq_q, irq_d;

  // address decode
  always_comb begin
    word    = bus_addr[ADDR_W-1:2];
    is_id   = &word[WORD_W-1:3];
    wr_ctrl = bus_wr & ~is_id & (word == WORD_W'(W_CTRL));
    wr_div  = bus_wr & ~is_id & (word == WORD_W'(W_DIV));
    wr_data = bus_wr & ~is_id & (word == WORD_W'(W_DATA));
    rd_data = bus_rd & ~is_id & (word == WORD_W'(W_DATA));
  end

  // next state of software registers and interrupt
  always_comb begin
    ctrl_d = wr_ctrl ? bus_wdata[BYTE_W-1:0] : ctrl_q;
    div_d  = wr_div  ? bus_wdata[BYTE_W-1:0] : div_q;
    irq_d  = (pending & ctrl_q[CT_RXIE]) | ctrl_q[CT_TXIE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      div_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q  <= ctrl_d;
      if (wr_div)  div_q   <= div_d;
      if (bus_rd)  rdata_q <= rdata_d;
    end
  end

  always_comb irq_q = irq_d;

  ps2r_rx_hold #(.BYTE_W(BYTE_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .consume   (rd_data),
    .pending   (pending),
    .rx_buf    (rx_buf),
    .last_byte (last_byte)
  );

  ps2r_read_mux #(.WORD_W(WORD_W), .BUS_W(BUS_W), .BYTE_W(BYTE_W)) u_rmux (
    .word      (word),
    .pending   (pending),
    .rx_buf    (rx_buf),
    .last_byte (last_byte),
    .ctrl      (ctrl_q),
    .div       (div_q),
    .rdata     (rdata_d)
  );

  ps2r_tx_port #(.BYTE_W(BYTE_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .send    (wr_data),
    .byte_in (bus_wdata[BYTE_W-1:0]),
    .tx_stb  (tx_stb),
    .tx_byte (tx_byte)
  );

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> $stable(bus_rdata)); // R1

  AST_TXIE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[CT_TXIE]) |=> irq); // R8

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !bus_wdata[CT_TXIE] && !bus_wdata[CT_RXIE]) |=> !irq); // R8

  AST_DIV_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_div |=> $stable(div_q)); // R12

endmodule

// File: tb/test_ps2_host_regs.sv
module test_ps2_host_regs;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic        bus_rd;
  logic [31:0] bus_rdata;
  logic        rx_valid;
  logic [7:0]  rx_byte;
  logic        tx_stb;
  logic [7:0]  tx_byte;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ps2_host_regs i_ps2_host_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_stb(tx_stb),
    .tx_byte(tx_byte), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  function automatic logic [31:0] stat_exp(input logic pend, input logic [7:0] held);
    return 32'h40 | (32'(pend) << 4) | (32'(^held) << 2);
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] prev;
    logic [7:0]  held;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    bus_rd = 1'b0; rx_valid = 1'b0; rx_byte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    rd(12'h000, v); check("R1 ctrl", v, 32'h0);
    rd(12'h00C, v); check("R1 div", v, 32'h0);
    rd(12'h004, v); check("R1 R3 status", v, 32'h40);
    rd(12'h008, v); check("R1 R6 data", v, 32'h0);
    rd(12'h010, v); check("R9 isr idle", v, 32'h2);
    // R1 read data holds while no read strobe
    prev = bus_rdata;
    repeat (3) @(negedge clk);
    check("R1 rdata hold", bus_rdata, prev);

    // R11 identification bytes
    begin
      logic [7:0] ids [8] = '{8'h50, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
      for (int i = 0; i < 8; i++) begin
        rd(12'hFE0 + 12'(4*i), v);
        check("R11 id", v, 32'(ids[i]));
      end
    end

    // R2 divisor sweep
    for (int d = 0; d < 256; d++) begin
      wr(12'h00C, 32'hFFFF_FF00 | 32'(d));
      rd(12'h00C, v);
      check("R2 div", v, 32'(d));
    end

    // R4 R5 sweep over every byte value
    held = 8'h00;
    for (int b = 0; b < 256; b++) begin
      push(8'(b));
      rd(12'h004, v); check("R3 R5 status pending", v, stat_exp(1'b1, held));
      rd(12'h008, v); check("R5 data", v, 32'(b));
      held = 8'(b);
      rd(12'h004, v); check("R4 parity", v, stat_exp(1'b0, held));
    end

    // R6 read with nothing pending repeats held byte
    rd(12'h008, v); check("R6 repeat", v, 32'(held));
    rd(12'h004, v); check("R6 status", v, stat_exp(1'b0, held));

    // R8 control sweep with pending clear and set
    for (int p = 0; p < 2; p++) begin
      if (p == 1) push(8'h3C);
      for (int c = 0; c < 256; c++) begin
        wr(12'h000, 32'hABCD_EF00 | 32'(c));
        check("R8 irq", 32'(irq), 32'((p[0] & c[4]) | c[3]));
        rd(12'h000, v); check("R2 ctrl", v, 32'(c));
      end
      rd(12'h010, v); check("R9 isr", v, 32'h2 | 32'(p[0]));
    end
    // consume pending with RX enable on: irq must drop
    wr(12'h000, 32'h10);
    check("R8 irq pend", 32'(irq), 32'h1);
    rd(12'h008, v); check("R5 data 3C", v, 32'h3C);
    @(negedge clk);
    check("R8 irq cleared", 32'(irq), 32'h0);
    held = 8'h3C;
    // irq rises when a byte arrives with enable on
    push(8'h81);
    check("R8 irq arrival", 32'(irq), 32'h1);

    // R7 arrival in the same cycle as a consuming read
    @(negedge clk);
    bus_addr = 12'h008; bus_rd = 1'b1; rx_valid = 1'b1; rx_byte = 8'h7E;
    @(negedge clk);
    bus_rd = 1'b0; rx_valid = 1'b0;
    check("R7 old byte", bus_rdata, 32'h81);
    rd(12'h004, v); check("R7 still pending", v, stat_exp(1'b1, 8'h81));
    rd(12'h008, v); check("R7 new byte", v, 32'h7E);
    rd(12'h004, v); check("R7 drained", v, stat_exp(1'b0, 8'h7E));
    // arrival during a read with nothing pending
    @(negedge clk);
    bus_addr = 12'h008; bus_rd = 1'b1; rx_valid = 1'b1; rx_byte = 8'h11;
    @(negedge clk);
    bus_rd = 1'b0; rx_valid = 1'b0;
    check("R7 R6 idle read", bus_rdata, 32'h7E);
    rd(12'h008, v); check("R7 late byte", v, 32'h11);

    // R10 transmit strobe
    for (int k = 0; k < 4; k++) begin
      wr(12'h008, 32'h1234_5600 | 32'(8'hA5 ^ 8'(k * 37)));
      check("R10 stb high", 32'(tx_stb), 32'h1);
      check("R10 byte", 32'(tx_byte), 32'(8'hA5 ^ 8'(k * 37)));
      @(negedge clk);
      check("R10 stb low", 32'(tx_stb), 32'h0);
    end

    // R12 unmapped reads and ignored writes
    wr(12'h000, 32'h22);
    wr(12'h00C, 32'h5A);
    rd(12'h014, v); check("R12 read 0x14", v, 32'h0);
    rd(12'h800, v); check("R12 read 0x800", v, 32'h0);
    rd(12'hFDC, v); check("R12 read 0xFDC", v, 32'h0);
    foreach (prev[i]) begin end
    begin
      logic [11:0] dead [5] = '{12'h014, 12'h004, 12'h010, 12'hFE8, 12'h400};
      for (int i = 0; i < 5; i++) begin
        wr(dead[i], 32'hFFFF_FFFF);
        check("R12 no stb", 32'(tx_stb), 32'h0);
      end
    end
    rd(12'h000, v); check("R12 ctrl kept", v, 32'h22);
    rd(12'h00C, v); check("R12 div kept", v, 32'h5A);
    rd(12'hFE8, v); check("R12 id kept", v, 32'h04);
    rd(12'h008, v); check("R12 held kept", v, 32'h11);

    finish_run();
  end

endmodule